// File: doc/BRIEF.md
# Stack Pointer Bounds and Alignment Checker

This block watches a core's stack pointer and every memory access that uses the stack pointer as its base register. It compares each one against the current thread's stack region. The stack is full-descending: the base is the high end of the region and the limit is the low end.

For each event the block reports up to three faults, one bit each:
- an alignment fault;
- a bounds fault;
- an access into the inactive part of the stack.

The inactive part is the stretch between the limit and the stack pointer. It lies inside the region, but no code may touch it.

A mode input picks 32-bit or 64-bit rules, and the alignment rules depend on both the mode and the kind of event. A privileged enable removes the alignment checks and leaves the bounds and region checks in force. The fault bits are registered, so they show the verdict on the event sampled at the previous clock edge.

The block recognises four event kinds, encoded on `ev_kind`:
- `00` SP_WRITE: a new stack-pointer value.
- `01` SP_ACCESS: a memory access at SP plus a signed byte offset, `acc_len` bytes long.
- `10` CALL_CHECK: a public-interface check point.
- `11` RESERVED: ignored.

Top module: `stk_guard`

## Requirements
- R1: The fault outputs change only on the clock edge that samples an event. They are all 0 after reset and in any cycle that follows a clock edge with `ev_valid` low.
- R2: For the kinds SP_WRITE, SP_ACCESS and CALL_CHECK, `flt_bounds` is set when SP is below `stk_limit` or above `stk_base`. SP equal to either bound is legal; SP equal to `stk_base` means an empty stack.
- R3: In 32-bit mode (`mode64`=0), an SP_WRITE with SP[1:0] not equal to 0 sets `flt_align`.
- R4: In 64-bit mode (`mode64`=1), an SP_WRITE never sets `flt_align`, whatever the low bits of SP are.
- R5: An SP_ACCESS sets `flt_align` when SP is not a multiple of 4 in 32-bit mode, or not a multiple of 16 in 64-bit mode.
- R6: A CALL_CHECK sets `flt_align` when SP is not a multiple of 8 in 32-bit mode, or not a multiple of 16 in 64-bit mode.
- R7: With `align_en`=0, `flt_align` stays 0 for every event. The other two fault bits behave as they do with `align_en`=1.
- R8: An SP_ACCESS touches the bytes [SP+`acc_off`, SP+`acc_off`+`acc_len`), where `acc_off` is two's complement. If any of those bytes lies below `stk_limit` or at or above `stk_base`, `flt_bounds` is set.
- R9: An SP_ACCESS with any byte in [`stk_limit`, SP) sets `flt_inactive`. An access whose bytes all lie in [SP, `stk_base`) sets no range fault. Only SP_ACCESS events can set `flt_inactive`.
- R10: An SP_ACCESS with `acc_len`=0 touches no byte, so it sets neither `flt_inactive` nor a range-based `flt_bounds`.
- R11: A RESERVED event sets no fault bit, whatever its SP.
- R12: When several faults apply to one event, all of their bits are set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode64 | input | 1 | 1 selects 64-bit rules, 0 selects 32-bit rules |
| align_en | input | 1 | Privileged enable for alignment checking |
| stk_base | input | AW | High end of the stack region (exclusive for data) |
| stk_limit | input | AW | Low end of the stack region |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 2 | Event kind (encoding in the description above) |
| ev_sp | input | AW | Stack pointer value of the event |
| acc_off | input | OFFW | Signed byte offset of an SP_ACCESS |
| acc_len | input | LENW | Byte count of an SP_ACCESS |
| flt_align | output | 1 | Alignment fault |
| flt_bounds | output | 1 | Bounds fault |
| flt_inactive | output | 1 | Inactive-region access fault |

## Verification
Stack-pointer values are placed exactly on the limit and on the base, and one word beyond each, to show the inclusive SP bounds. Accesses are walked across the upper edge of the active region and down into the inactive region, to separate a bounds fault from an inactive-region fault. One access spans both the limit and SP, to show that two faults can be raised together.

The same misaligned SP values are sent as a write, an access and a check point in both modes. This shows that the alignment rule follows the event kind and not only the mode. Zero-length accesses, reserved events and runs with alignment disabled show that those cases leave the outputs clear.

// File: rtl/stk_guard_pkg.sv
package stk_guard_pkg;

    typedef enum logic [1:0] {
        EV_SP_WRITE   = 2'b00,
        EV_SP_ACCESS  = 2'b01,
        EV_CALL_CHECK = 2'b10,
        EV_RESERVED   = 2'b11
    } ev_kind_t;

    typedef struct packed {
        logic align;
        logic bounds;
        logic inactive;
    } fault_t;

endpackage

// File: rtl/stk_align_unit.sv
module stk_align_unit
    import stk_guard_pkg::*;
#(
    parameter int AW          = 32,
    parameter int EXP32_ANY   = 2,   // every SP value, 32-bit
    parameter int EXP32_CALL  = 3,   // check point, 32-bit
    parameter int EXP64_MEM   = 4,   // SP-based access, 64-bit
    parameter int EXP64_CALL  = 4    // check point, 64-bit
) (
    input  ev_kind_t        kind,
    input  logic            mode64,
    input  logic [AW-1:0]   sp,
    output logic            misaligned
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] mask;
    logic          rule_on;

    always_comb begin
        rule_on = 1'b1;
        mask    = '0;
        unique case (kind)
            EV_SP_WRITE: begin
                // 64-bit rules allow any SP value that is not used for memory
                rule_on = !mode64;
                mask    = (ONE << EXP32_ANY) - ONE;
            end
            EV_SP_ACCESS: begin
                mask = mode64 ? (ONE << EXP64_MEM) - ONE
                              : (ONE << EXP32_ANY) - ONE;
            end
            EV_CALL_CHECK: begin
                mask = mode64 ? (ONE << EXP64_CALL) - ONE
                              : (ONE << EXP32_CALL) - ONE;
            end
            EV_RESERVED: begin
                rule_on = 1'b0;
            end
        endcase
    end

    assign misaligned = rule_on && (|(sp & mask));

endmodule

// File: rtl/stk_bounds_unit.sv
module stk_bounds_unit #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          sp_outside
);

    // SP may sit on either end: on the base the stack is empty,
    // on the limit it is full.
    assign sp_outside = (sp < limit) || (sp > base);

endmodule

// File: rtl/stk_range_unit.sv
module stk_range_unit #(
    parameter int AW   = 32,
    parameter int OFFW = 12,
    parameter int LENW = 5
) (
    input  logic [AW-1:0]   sp,
    input  logic [OFFW-1:0] off,
    input  logic [LENW-1:0] len,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   limit,
    output logic            out_of_region,
    output logic            hits_inactive
);

    // Two extra bits keep sums from wrapping and leave room for a sign.
    localparam int SW = AW + 2;

    logic signed [SW-1:0] sp_s, base_s, limit_s, off_s, len_s;
    logic signed [SW-1:0] lo_s, hi_s;
    logic                 has_bytes;

    assign sp_s    = $signed({2'b00, sp});
    assign base_s  = $signed({2'b00, base});
    assign limit_s = $signed({2'b00, limit});
    assign off_s   = $signed({{(SW-OFFW){off[OFFW-1]}}, off});
    assign len_s   = $signed({{(SW-LENW){1'b0}}, len});

    assign lo_s      = sp_s + off_s;   // first byte touched
    assign hi_s      = lo_s + len_s;   // one past the last byte
    assign has_bytes = (len != '0);

    // Some byte falls below the limit or at/above the base.
    assign out_of_region = has_bytes && ((lo_s < limit_s) || (hi_s > base_s));

    // [lo, hi) overlaps [limit, sp).
    assign hits_inactive = has_bytes && (lo_s < sp_s) && (hi_s > limit_s)
                           && (limit_s < sp_s);

endmodule

// File: rtl/stk_guard.sv
module stk_guard
    import stk_guard_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 12,
    parameter int LENW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode64,
    input  logic            align_en,
    input  logic [AW-1:0]   stk_base,
    input  logic [AW-1:0]   stk_limit,
    input  logic            ev_valid,
    input  logic [1:0]      ev_kind,
    input  logic [AW-1:0]   ev_sp,
    input  logic [OFFW-1:0] acc_off,
    input  logic [LENW-1:0] acc_len,
    output logic            flt_align,
    output logic            flt_bounds,
    output logic            flt_inactive
);

    ev_kind_t kind;
    logic     misaligned;
    logic     sp_outside;
    logic     out_of_region;
    logic     hits_inactive;
    fault_t   nxt_q, flt_q;

    assign kind = ev_kind_t'(ev_kind);

    stk_align_unit #(.AW(AW)) u_align (
        .kind       (kind),
        .mode64     (mode64),
        .sp         (ev_sp),
        .misaligned (misaligned)
    );

    stk_bounds_unit #(.AW(AW)) u_bounds (
        .sp         (ev_sp),
        .base       (stk_base),
        .limit      (stk_limit),
        .sp_outside (sp_outside)
    );

    stk_range_unit #(.AW(AW), .OFFW(OFFW), .LENW(LENW)) u_range (
        .sp            (ev_sp),
        .off           (acc_off),
        .len           (acc_len),
        .base          (stk_base),
        .limit         (stk_limit),
        .out_of_region (out_of_region),
        .hits_inactive (hits_inactive)
    );

    // Verdict for the event on the inputs this cycle.
    always_comb begin
        nxt_q = '0;
        if (ev_valid) begin
            unique case (kind)
                EV_SP_WRITE, EV_CALL_CHECK: begin
                    nxt_q.align  = misaligned && align_en;
                    nxt_q.bounds = sp_outside;
                end
                EV_SP_ACCESS: begin
                    nxt_q.align    = misaligned && align_en;
                    nxt_q.bounds   = sp_outside || out_of_region;
                    nxt_q.inactive = hits_inactive;
                end
                EV_RESERVED: begin
                    nxt_q = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= nxt_q;
    end

    assign flt_align    = flt_q.align;
    assign flt_bounds   = flt_q.bounds;
    assign flt_inactive = flt_q.inactive;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ev_valid) |-> !(flt_align || flt_bounds || flt_inactive));

    p_sp_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_valid && (ev_kind != 2'b11)
              && ((ev_sp < stk_limit) || (ev_sp > stk_base))) |-> flt_bounds);

    p_align_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_valid && !align_en) |-> !flt_align);

    p_inactive_access_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_valid && (ev_kind != 2'b01)) |-> !flt_inactive);

    p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_valid && (ev_kind == 2'b11))
            |-> !(flt_align || flt_bounds || flt_inactive));

endmodule

// File: tb/test_stk_guard.sv
module test_stk_guard;

    localparam int AW   = 32;
    localparam int OFFW = 12;
    localparam int LENW = 5;

    localparam logic [1:0] K_WR  = 2'b00;
    localparam logic [1:0] K_ACC = 2'b01;
    localparam logic [1:0] K_CHK = 2'b10;
    localparam logic [1:0] K_RSV = 2'b11;

    localparam logic [AW-1:0] BASE  = 32'h0000_1000;
    localparam logic [AW-1:0] LIMIT = 32'h0000_0800;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode64 = 1'b0;
    logic            align_en = 1'b1;
    logic [AW-1:0]   stk_base = BASE;
    logic [AW-1:0]   stk_limit = LIMIT;
    logic            ev_valid = 1'b0;
    logic [1:0]      ev_kind = 2'b00;
    logic [AW-1:0]   ev_sp = '0;
    logic [OFFW-1:0] acc_off = '0;
    logic [LENW-1:0] acc_len = '0;
    logic            flt_align, flt_bounds, flt_inactive;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    stk_guard #(.AW(AW), .OFFW(OFFW), .LENW(LENW)) i_stk_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode64       (mode64),
        .align_en     (align_en),
        .stk_base     (stk_base),
        .stk_limit    (stk_limit),
        .ev_valid     (ev_valid),
        .ev_kind      (ev_kind),
        .ev_sp        (ev_sp),
        .acc_off      (acc_off),
        .acc_len      (acc_len),
        .flt_align    (flt_align),
        .flt_bounds   (flt_bounds),
        .flt_inactive (flt_inactive)
    );

    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {flt_align, flt_bounds, flt_inactive};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {align,bounds,inactive} actual %b expected %b", tag, act, exp);
        end
    endtask

    // Present one event for one cycle, check the registered verdict,
    // then check that an idle cycle clears it (R1).
    task automatic ev(input logic [1:0] k, input logic [AW-1:0] sp,
                      input int off, input int len,
                      input logic [2:0] exp, input string tag);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind  = k;
        ev_sp    = sp;
        acc_off  = OFFW'(off);
        acc_len  = LENW'(len);
        @(negedge clk);
        ev_valid = 1'b0;
        chk(tag, exp);
        @(negedge clk);
        chk("R1 idle after event", 3'b000);
    endtask

    task automatic t_reset;
        chk("R1 reset state", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 3'b000);
    endtask

    task automatic t_sp_write32;
        mode64 = 1'b0;
        ev(K_WR, 32'h0F00, 0, 0, 3'b000, "R3 aligned write");
        ev(K_WR, 32'h0F02, 0, 0, 3'b100, "R3 misaligned write");
        ev(K_WR, BASE,     0, 0, 3'b000, "R2 SP at base");
        ev(K_WR, LIMIT,    0, 0, 3'b000, "R2 SP at limit");
        ev(K_WR, 32'h1004, 0, 0, 3'b010, "R2 SP above base");
        ev(K_WR, 32'h07FC, 0, 0, 3'b010, "R2 SP below limit");
    endtask

    task automatic t_checkpoint32;
        mode64 = 1'b0;
        ev(K_CHK, 32'h0F04, 0, 0, 3'b100, "R6 32-bit check point 4-aligned");
        ev(K_CHK, 32'h0F08, 0, 0, 3'b000, "R6 32-bit check point 8-aligned");
        ev(K_CHK, 32'h1008, 0, 0, 3'b010, "R2 check point above base");
    endtask

    task automatic t_access32;
        mode64 = 1'b0;
        ev(K_ACC, 32'h0F00, 0,    4, 3'b000, "R9 access at SP");
        ev(K_ACC, 32'h0F00, 'hFC, 4, 3'b000, "R9 access ending at base");
        ev(K_ACC, 32'h0F00, 'hFE, 4, 3'b010, "R8 access crossing base");
        ev(K_ACC, 32'h0F00, -4,   4, 3'b001, "R9 access just below SP");
        ev(K_ACC, 32'h0F00, -2,   4, 3'b001, "R9 access straddling SP");
        ev(K_ACC, 32'h0F02, 0,    2, 3'b100, "R5 32-bit access misaligned");
    endtask

    task automatic t_multi;
        mode64 = 1'b0;
        // bytes 0x7FC..0x803: below limit and inside [limit, SP)
        ev(K_ACC, 32'h0F00, -32'h704, 8, 3'b011, "R12 bounds and inactive");
        ev(K_ACC, 32'h0F02, -32'h704, 8, 3'b111, "R12 all three faults");
    endtask

    task automatic t_len0;
        ev(K_ACC, 32'h0F00, -8,    0, 3'b000, "R10 empty access below SP");
        ev(K_ACC, 32'h0F00, 'h200, 0, 3'b000, "R10 empty access past base");
    endtask

    task automatic t_reserved;
        ev(K_RSV, 32'h2003, -8, 4, 3'b000, "R11 reserved kind ignored");
    endtask

    task automatic t_align_off;
        mode64   = 1'b0;
        align_en = 1'b0;
        ev(K_WR,  32'h0F02, 0,  0, 3'b000, "R7 write misalign masked");
        ev(K_WR,  32'h1002, 0,  0, 3'b010, "R7 bounds kept when masked");
        ev(K_ACC, 32'h0F02, -4, 4, 3'b001, "R7 inactive kept when masked");
        align_en = 1'b1;
    endtask

    task automatic t_mode64;
        mode64 = 1'b1;
        ev(K_WR,  32'h0F08, 0, 0,  3'b000, "R4 64-bit write not 16-aligned");
        ev(K_WR,  32'h0F03, 0, 0,  3'b000, "R4 64-bit write odd SP");
        ev(K_ACC, 32'h0F08, 0, 8,  3'b100, "R5 64-bit access 8-aligned");
        ev(K_ACC, 32'h0F10, 0, 16, 3'b000, "R5 64-bit access 16-aligned");
        ev(K_CHK, 32'h0F08, 0, 0,  3'b100, "R6 64-bit check point 8-aligned");
        ev(K_CHK, 32'h0F10, 0, 0,  3'b000, "R6 64-bit check point 16-aligned");
        mode64 = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sp_write32();
        t_checkpoint32();
        t_access32();
        t_multi();
        t_len0();
        t_reserved();
        t_align_off();
        t_mode64();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule